// File: doc/BRIEF.md
# Addressable RGB LED Chain Serializer

This block drives a daisy chain of single-wire RGB LEDs from a small pixel store held in flip-flops. Each LED takes a 24-bit colour word. A one-cycle send request streams the whole chain on one output pin. Every bit occupies a fixed slot of twenty ticks, and the bit value is coded in the width of the high part of the slot. Each frame has one low slot before the first data bit and eight low slots after the last one. The trailing low time lets the LEDs latch the new colours.

Colour updates arrive on a write port. The port carries a base LED index, a small LED mask and three colour bytes. One write can therefore paint several neighbouring LEDs with the same colour. The active chain length lives in a count register. That register can only grow and saturates at the build maximum. A send that arrives during a frame is remembered and started as soon as that frame ends. The `busy` output stays high across such back-to-back frames.

The block is controlled by a four-state machine. IDLE waits for a send and moves to LEAD_PAD. LEAD_PAD sends the leading low slots and then moves to PIXEL_BITS, or straight to TAIL_PAD when the count is zero. PIXEL_BITS walks the LEDs from index 0 upward and moves to TAIL_PAD after bit 0 of the last LED. TAIL_PAD sends the trailing low slots. It then returns to LEAD_PAD if a send is pending or arriving, and to IDLE otherwise.

Top module: `led_chain_serializer`

## Requirements
- R1: After reset `dout` and `busy` are low, the LED count is 0, and every stored pixel is zero, so a frame after the count is raised codes every data bit as 0.
- R2: Every bit slot is SLOT_TICKS (20) ticks long. A 0 bit is high for ZERO_HIGH (7) ticks and a 1 bit is high for ONE_HIGH (14) ticks, both starting at the beginning of the slot; the rest of the slot is low.
- R3: For each LED, data goes out as green byte, then red byte, then blue byte, each most significant bit first. LEDs go out in index order starting at 0.
- R4: A frame starts with LEAD_SLOTS (1) fully low slot. `dout` rises for the first time SLOT_TICKS*CLKS_PER_TICK+1 cycles after the clock edge that accepts `send`.
- R5: `busy` rises on the edge after an accepted `send` and stays high for exactly (24*count + LEAD_SLOTS + TAIL_SLOTS)*SLOT_TICKS*CLKS_PER_TICK cycles. The frame ends with TAIL_SLOTS (8) low slots.
- R6: A write with base index b and mask m sets the colour of LED b+k for every set bit k of m. This happens only where b+k is below the current LED count; other LEDs keep their colour.
- R7: A count request is first clamped to MAX_LEDS. The count becomes the larger of its old value and the clamped request, so a smaller request is ignored.
- R8: A `send` while `busy` is high is held pending. The next frame starts right after the current one with `busy` staying high, and several sends during one frame give exactly one more frame.
- R9: `dout` is low in every cycle in which `busy` was low on the previous cycle.
- R10: One tick lasts CLKS_PER_TICK clock cycles, so every slot and pulse length above scales by that factor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Apply `cfg_count` to the LED count register |
| cfg_count | input | CNT_W | Requested LED count |
| wr_valid | input | 1 | Apply one colour write |
| wr_base | input | IDX_W | Index of the LED that mask bit 0 selects |
| wr_mask | input | MASK_W | Bit k selects LED wr_base+k |
| wr_red | input | 8 | Red byte |
| wr_green | input | 8 | Green byte |
| wr_blue | input | 8 | Blue byte |
| send | input | 1 | Request one frame |
| dout | output | 1 | Serial LED data |
| busy | output | 1 | A frame is being sent |

## Verification
The bench builds the block with MAX_LEDS=5, MASK_W=4 and CLKS_PER_TICK=2. With a chain this short, full frames stay only a few thousand cycles long, so every frame can be decoded pulse by pulse and compared against a model. Five LEDs with a four-bit mask let a write run past the configured count and past the last LED, and a count request of 7 exercises the clamp. A tick of two cycles shows that pulse widths and slot lengths scale with the prescaler and are not fixed in clock cycles.

// File: rtl/led_ser_pkg.sv
package led_ser_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD_PAD,
        ST_PIXEL_BITS,
        ST_TAIL_PAD
    } led_state_t;

    localparam int COLOR_BITS  = 8;
    localparam int PIXEL_BITS  = 3 * COLOR_BITS;
    localparam int BITSEL_W    = $clog2(PIXEL_BITS);

    typedef logic [PIXEL_BITS-1:0] grb_word_t;

endpackage

// File: rtl/led_pixel_store.sv
module led_pixel_store
    import led_ser_pkg::*;
#(
    parameter int MAX_LEDS = 8,
    parameter int MASK_W   = 8,
    parameter int IDX_W    = 3,
    parameter int CNT_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_valid,
    input  logic [CNT_W-1:0] cfg_count,
    input  logic             wr_valid,
    input  logic [IDX_W-1:0] wr_base,
    input  logic [MASK_W-1:0] wr_mask,
    input  grb_word_t        wr_grb,
    input  logic [IDX_W-1:0] rd_idx,
    output grb_word_t        rd_grb,
    output logic [CNT_W-1:0] led_count
);

    localparam int SHIFT_W = MAX_LEDS + MASK_W;
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_LEDS);

    grb_word_t            pix [MAX_LEDS];
    logic [MAX_LEDS-1:0]  sel;
    logic [CNT_W-1:0]     req_clamped;

    // Mask bit k lands on LED wr_base+k; bits past the last LED fall off.
    always_comb begin
        sel = MAX_LEDS'({{MAX_LEDS{1'b0}}, wr_mask} << wr_base);
    end

    always_comb begin
        req_clamped = (cfg_count > CNT_MAX) ? CNT_MAX : cfg_count;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            led_count <= '0;
        end else if (cfg_valid && (req_clamped > led_count)) begin
            led_count <= req_clamped;
        end
    end

    for (genvar i = 0; i < MAX_LEDS; i++) begin : g_led
        grb_word_t word_q;
        logic      hit;

        always_comb begin
            hit = wr_valid && sel[i] && (CNT_W'(i) < led_count);
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (hit) begin
                word_q <= wr_grb;
            end
        end

        assign pix[i] = word_q;
    end

    always_comb begin
        if (int'(rd_idx) < MAX_LEDS) begin
            rd_grb = pix[rd_idx];
        end else begin
            rd_grb = '0;
        end
    end

endmodule

// File: rtl/led_slot_timer.sv
module led_slot_timer #(
    parameter int CLKS_PER_TICK = 5,
    parameter int SLOT_TICKS    = 20,
    parameter int ONE_HIGH      = 14,
    parameter int ZERO_HIGH     = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic data_slot,
    input  logic bit_val,
    output logic level,
    output logic slot_end
);

    localparam int PRE_W  = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;
    localparam int TICK_W = $clog2(SLOT_TICKS);
    localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(SLOT_TICKS - 1);
    localparam logic [TICK_W-1:0] HI_ONE    = TICK_W'(ONE_HIGH);
    localparam logic [TICK_W-1:0] HI_ZERO   = TICK_W'(ZERO_HIGH);

    logic [TICK_W-1:0] tick_cnt;
    logic              tick_en;

    if (CLKS_PER_TICK > 1) begin : g_prescale
        localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLKS_PER_TICK - 1);
        logic [PRE_W-1:0] pre_cnt;

        always_ff @(posedge clk) begin
            if (!rst_n || !run) begin
                pre_cnt <= '0;
            end else if (pre_cnt == PRE_LAST) begin
                pre_cnt <= '0;
            end else begin
                pre_cnt <= pre_cnt + 1'b1;
            end
        end

        assign tick_en = (pre_cnt == PRE_LAST);
    end else begin : g_direct
        assign tick_en = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            tick_cnt <= '0;
        end else if (tick_en) begin
            tick_cnt <= (tick_cnt == TICK_LAST) ? '0 : tick_cnt + 1'b1;
        end
    end

    always_comb begin
        slot_end = run && tick_en && (tick_cnt == TICK_LAST);
        level    = run && data_slot && (tick_cnt < (bit_val ? HI_ONE : HI_ZERO));
    end

endmodule

// File: rtl/led_frame_fsm.sv
module led_frame_fsm
    import led_ser_pkg::*;
#(
    parameter int MAX_LEDS   = 8,
    parameter int IDX_W      = 3,
    parameter int CNT_W      = 4,
    parameter int LEAD_SLOTS = 1,
    parameter int TAIL_SLOTS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             send,
    input  logic [CNT_W-1:0] led_count,
    input  logic             slot_end,
    input  grb_word_t        rd_grb,
    output logic [IDX_W-1:0] rd_idx,
    output logic             bit_val,
    output logic             data_slot,
    output logic             busy
);

    localparam int PAD_MAX = (LEAD_SLOTS > TAIL_SLOTS) ? LEAD_SLOTS : TAIL_SLOTS;
    localparam int PAD_W   = $clog2(PAD_MAX + 1);
    localparam logic [PAD_W-1:0]    LEAD_LAST = PAD_W'(LEAD_SLOTS - 1);
    localparam logic [PAD_W-1:0]    TAIL_LAST = PAD_W'(TAIL_SLOTS - 1);
    localparam logic [BITSEL_W-1:0] BIT_LAST  = BITSEL_W'(PIXEL_BITS - 1);

    led_state_t          state, state_nx;
    logic [IDX_W-1:0]    led_idx;
    logic [BITSEL_W-1:0] bit_idx;
    logic [PAD_W-1:0]    pad_cnt;
    logic                pending;
    logic                last_led;

    always_comb begin
        last_led = (CNT_W'(led_idx) + 1'b1) >= led_count;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (send) state_nx = ST_LEAD_PAD;
            end
            ST_LEAD_PAD: begin
                if (slot_end && pad_cnt == LEAD_LAST) begin
                    state_nx = (led_count == '0) ? ST_TAIL_PAD : ST_PIXEL_BITS;
                end
            end
            ST_PIXEL_BITS: begin
                if (slot_end && bit_idx == BIT_LAST && last_led) begin
                    state_nx = ST_TAIL_PAD;
                end
            end
            ST_TAIL_PAD: begin
                if (slot_end && pad_cnt == TAIL_LAST) begin
                    state_nx = (pending || send) ? ST_LEAD_PAD : ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            led_idx <= '0;
            bit_idx <= '0;
            pad_cnt <= '0;
        end else if (state_nx != state) begin
            led_idx <= '0;
            bit_idx <= '0;
            pad_cnt <= '0;
        end else if (slot_end) begin
            if (state == ST_PIXEL_BITS) begin
                if (bit_idx == BIT_LAST) begin
                    bit_idx <= '0;
                    led_idx <= led_idx + 1'b1;
                end else begin
                    bit_idx <= bit_idx + 1'b1;
                end
            end else begin
                pad_cnt <= pad_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (state == ST_TAIL_PAD && state_nx == ST_LEAD_PAD) begin
            pending <= 1'b0;
        end else if (send && state != ST_IDLE) begin
            pending <= 1'b1;
        end
    end

    always_comb begin
        busy      = (state != ST_IDLE);
        data_slot = (state == ST_PIXEL_BITS);
        rd_idx    = led_idx;
        bit_val   = rd_grb[BIT_LAST - bit_idx];
    end

endmodule

// File: rtl/led_chain_serializer.sv
module led_chain_serializer
    import led_ser_pkg::*;
#(
    parameter int MAX_LEDS      = 8,
    parameter int MASK_W        = 8,
    parameter int CLKS_PER_TICK = 5,
    parameter int SLOT_TICKS    = 20,
    parameter int ONE_HIGH      = 14,
    parameter int ZERO_HIGH     = 7,
    parameter int LEAD_SLOTS    = 1,
    parameter int TAIL_SLOTS    = 8,
    localparam int IDX_W        = (MAX_LEDS > 1) ? $clog2(MAX_LEDS) : 1,
    localparam int CNT_W        = $clog2(MAX_LEDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic              wr_valid,
    input  logic [IDX_W-1:0]  wr_base,
    input  logic [MASK_W-1:0] wr_mask,
    input  logic [7:0]        wr_red,
    input  logic [7:0]        wr_green,
    input  logic [7:0]        wr_blue,
    input  logic              send,
    output logic              dout,
    output logic              busy
);

    logic [CNT_W-1:0] led_count;
    logic [IDX_W-1:0] rd_idx;
    grb_word_t        rd_grb;
    logic             bit_val;
    logic             data_slot;
    logic             slot_end;
    logic             level;

    led_pixel_store #(
        .MAX_LEDS (MAX_LEDS),
        .MASK_W   (MASK_W),
        .IDX_W    (IDX_W),
        .CNT_W    (CNT_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_valid (cfg_valid),
        .cfg_count (cfg_count),
        .wr_valid  (wr_valid),
        .wr_base   (wr_base),
        .wr_mask   (wr_mask),
        .wr_grb    ({wr_green, wr_red, wr_blue}),
        .rd_idx    (rd_idx),
        .rd_grb    (rd_grb),
        .led_count (led_count)
    );

    led_frame_fsm #(
        .MAX_LEDS   (MAX_LEDS),
        .IDX_W      (IDX_W),
        .CNT_W      (CNT_W),
        .LEAD_SLOTS (LEAD_SLOTS),
        .TAIL_SLOTS (TAIL_SLOTS)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .send      (send),
        .led_count (led_count),
        .slot_end  (slot_end),
        .rd_grb    (rd_grb),
        .rd_idx    (rd_idx),
        .bit_val   (bit_val),
        .data_slot (data_slot),
        .busy      (busy)
    );

    led_slot_timer #(
        .CLKS_PER_TICK (CLKS_PER_TICK),
        .SLOT_TICKS    (SLOT_TICKS),
        .ONE_HIGH      (ONE_HIGH),
        .ZERO_HIGH     (ZERO_HIGH)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy),
        .data_slot (data_slot),
        .bit_val   (bit_val),
        .level     (level),
        .slot_end  (slot_end)
    );

    // The pin is driven from a flop so that it carries no glitches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= 1'b0;
        end else begin
            dout <= level;
        end
    end

endmodule

// File: rtl/led_chain_serializer_chk.sv
module led_chain_serializer_chk #(
    parameter int CNT_W    = 4,
    parameter int MAX_LEDS = 8,
    parameter int MAX_HIGH = 70
) (
    input logic             clk,
    input logic             rst_n,
    input logic             send,
    input logic             busy,
    input logic             dout,
    input logic [CNT_W-1:0] led_count
);

    logic [15:0] hi_run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run <= '0;
        end else if (dout) begin
            hi_run <= hi_run + 1'b1;
        end else begin
            hi_run <= '0;
        end
    end

    a_r9_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !dout);

    a_r4_frame_opens_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !dout);

    a_r5_send_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (send && !busy) |=> busy);

    a_r8_pending_keeps_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (send && busy) |=> busy);

    a_r2_pulse_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        hi_run <= 16'(MAX_HIGH));

    a_r7_count_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> led_count >= $past(led_count));

    a_r7_count_clamped: assert property (@(posedge clk) disable iff (!rst_n)
        led_count <= CNT_W'(MAX_LEDS));

endmodule

bind led_chain_serializer led_chain_serializer_chk #(
    .CNT_W    (CNT_W),
    .MAX_LEDS (MAX_LEDS),
    .MAX_HIGH (ONE_HIGH * CLKS_PER_TICK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .send      (send),
    .busy      (busy),
    .dout      (dout),
    .led_count (led_count)
);

// File: tb/led_chain_serializer_test.sv
`timescale 1ns/1ps
module led_chain_serializer_test;

    localparam int MAXL  = 5;
    localparam int MW    = 4;
    localparam int CPT   = 2;
    localparam int SLOT  = 20;
    localparam int IW    = $clog2(MAXL);
    localparam int CW    = $clog2(MAXL + 1);
    localparam int SLOTC = SLOT * CPT;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_valid = 1'b0;
    logic [CW-1:0] cfg_count = '0;
    logic          wr_valid = 1'b0;
    logic [IW-1:0] wr_base = '0;
    logic [MW-1:0] wr_mask = '0;
    logic [7:0]    wr_red = '0, wr_green = '0, wr_blue = '0;
    logic          send = 1'b0;
    logic          dout, busy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [23:0] exp_pix [MAXL];
    int          exp_cnt = 0;

    always #4 clk = ~clk;

    led_chain_serializer #(
        .MAX_LEDS(MAXL), .MASK_W(MW), .CLKS_PER_TICK(CPT)
    ) uut (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_count(cfg_count),
        .wr_valid(wr_valid), .wr_base(wr_base), .wr_mask(wr_mask),
        .wr_red(wr_red), .wr_green(wr_green), .wr_blue(wr_blue),
        .send(send), .dout(dout), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int clamp_max(input int req);
        return (req > MAXL) ? MAXL : req;
    endfunction

    task automatic do_cfg(input int n);
        @(negedge clk);
        cfg_valid = 1'b1; cfg_count = CW'(n);
        @(negedge clk);
        cfg_valid = 1'b0;
        if (clamp_max(n) > exp_cnt) exp_cnt = clamp_max(n);
    endtask

    task automatic do_write(input int base, input int mask,
                            input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
        @(negedge clk);
        wr_valid = 1'b1; wr_base = IW'(base); wr_mask = MW'(mask);
        wr_red = r; wr_green = g; wr_blue = b;
        @(negedge clk);
        wr_valid = 1'b0;
        for (int k = 0; k < MW; k++) begin
            if (mask[k] && (base + k) < exp_cnt && (base + k) < MAXL)
                exp_pix[base + k] = {g, r, b};
        end
    endtask

    // Sends one frame (or two when dbl) and decodes the pin pulse by pulse.
    task automatic run_frame(input bit dbl, input string tag);
        int runs[$];
        int busy_n = 0, lead0 = 0, run = 0, guard = 0;
        int frames = dbl ? 2 : 1;
        int bad = -1, bad_act = 0, bad_exp = 0, n = 0;
        bit seen = 1'b0;
        @(negedge clk) send = 1'b1;
        @(negedge clk) send = 1'b0;
        forever begin
            if (busy) busy_n++;
            if (dout) begin
                seen = 1'b1; run++;
            end else begin
                if (run > 0) runs.push_back(run);
                run = 0;
                if (!seen) lead0++;
            end
            if (!busy || guard > 20000) break;
            guard++;
            send = dbl && (busy_n == 100 || busy_n == 300);
            @(negedge clk);
        end
        send = 1'b0;
        check(busy_n == frames * (24 * exp_cnt + 9) * SLOTC, dbl ? "R8" : "R5",
              {tag, " busy length"}, busy_n, frames * (24 * exp_cnt + 9) * SLOTC);
        check(runs.size() == frames * 24 * exp_cnt, "R3", {tag, " pulse count"},
              runs.size(), frames * 24 * exp_cnt);
        for (int f = 0; f < frames; f++)
            for (int l = 0; l < exp_cnt; l++)
                for (int b = 23; b >= 0; b--) begin
                    int want = exp_pix[l][b] ? 14 * CPT : 7 * CPT;
                    int got = (n < runs.size()) ? runs[n] : -1;
                    if (bad < 0 && got != want) begin
                        bad = n; bad_act = got; bad_exp = want;
                    end
                    n++;
                end
        check(bad < 0, "R2,R3,R10", {tag, " pulse widths"}, bad_act, bad_exp);
        if (exp_cnt > 0)
            check(lead0 == SLOTC + 1, "R4", {tag, " lead low cycles"}, lead0, SLOTC + 1);
        @(negedge clk);
        check(!dout && !busy, "R9", {tag, " idle after frame"}, int'(dout), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < MAXL; i++) exp_pix[i] = '0;
        repeat (4) @(negedge clk);
        check(!dout, "R1", "reset dout", int'(dout), 0);
        check(!busy, "R1", "reset busy", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);

        run_frame(1'b0, "R1 empty chain");
        do_cfg(3);
        run_frame(1'b0, "R1 zero pixels");

        // Only LED 1 is below the count of 3; LED 3 must stay dark (R6).
        do_write(1, 4'b0101, 8'h3C, 8'hA5, 8'h81);
        run_frame(1'b0, "R6 masked write");

        do_cfg(2);                                   // R7 shrink ignored
        run_frame(1'b0, "R7 shrink ignored");
        do_cfg(7);                                   // R7 clamps to 5
        run_frame(1'b0, "R7 clamp");

        do_write(3, 4'b1111, 8'hFF, 8'h00, 8'h5A);   // R6 runs past last LED
        do_write(0, 4'b0001, 8'h80, 8'h01, 8'hFE);
        run_frame(1'b0, "R6 edge write");

        for (int round = 0; round < 3; round++) begin
            for (int w = 0; w < 3; w++)
                do_write($urandom_range(0, MAXL - 1), $urandom_range(0, 15),
                         8'($urandom), 8'($urandom), 8'($urandom));
            run_frame(1'b0, "R3 random");
        end

        run_frame(1'b1, "R8 pending");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule